// File: doc/BRIEF.md
# Posted-CAS Data Window Scheduler

This block sits between the command arbiter of a DDR2-class memory controller and the data-path serialiser. Each granted column command (read or write) enters in the cycle it is presented. The block works out which future clock cycles the data burst of that command will take on the shared data bus and produces, cycle by cycle, the strobes the data path needs. These are a read-capture enable, a write-drive enable that opens one cycle early for the strobe preamble, and a write data-mask window that covers exactly the write beats.

Read latency is the sum of a programmable CAS latency and a programmable additive latency. The additive latency allows a column command to be posted early. Write latency is always one cycle less than read latency. Data moves on both clock edges, so a burst of 4 or 8 beats holds the bus for 2 or 4 clock cycles. Bus occupancy is kept in a shift-style timeline of future cycles, each slot tagged idle, read or write, so any number of bursts that fit the window can be outstanding. A command whose window would overlap a scheduled one, or would place write data straight after read data without an idle cycle between them, is refused in the same cycle.

Configuration is loaded through a strobe. A load is taken only when the timeline is empty, when no command is presented in that cycle, and when the values are legal.

Top module: `posted_cas_sched`

## Requirements
- R1: In reset and right after it, rd_capture_en, wr_drive_en, wr_dm_window, cmd_accept and cmd_collide are 0. The reset configuration is CAS latency 3, additive latency 0 and burst of 4 beats.
- R2: A read accepted in cycle c raises rd_capture_en in cycles c+AL+CL through c+AL+CL+B-1, where B is the burst length in clock cycles.
- R3: A write accepted in cycle c raises wr_dm_window in cycles c+AL+CL-1 through c+AL+CL+B-2, so write latency is read latency minus one.
- R4: wr_drive_en is high in the cycle just before every write data-mask window and throughout that window, and is low at all other times.
- R5: cfg_bl8=1 selects 8-beat bursts (B=4 cycles) and cfg_bl8=0 selects 4-beat bursts (B=2 cycles).
- R6: A command whose data cycles overlap any cycle already scheduled is refused (cmd_collide=1, cmd_accept=0) and leaves the strobes unchanged. Windows that abut with no idle cycle between them are accepted.
- R7: A write whose first data cycle directly follows a scheduled read data cycle is refused. A write whose data is separated from read data by one idle cycle is accepted. A read may directly follow write data.
- R8: A configuration load is ignored while any burst is outstanding, and also in a cycle where cmd_valid is high.
- R9: A configuration load with CAS latency outside 3..6 or additive latency above 4 is ignored.
- R10: cmd_accept and cmd_collide are never both high, and both are 0 when cmd_valid is 0.
- R11: Back-to-back bursts at the largest latency (AL=4, CL=6) can be outstanding together, at least four of them, giving a gapless read stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Request to load new latency/burst settings |
| cfg_cl | input | 3 | CAS latency to load (3..6) |
| cfg_al | input | 3 | Additive latency to load (0..4) |
| cfg_bl8 | input | 1 | 1: 8-beat bursts, 0: 4-beat bursts |
| cmd_valid | input | 1 | A granted column command is presented |
| cmd_write | input | 1 | 1: write command, 0: read command |
| cmd_accept | output | 1 | Command scheduled this cycle |
| cmd_collide | output | 1 | Command refused because of a bus conflict |
| rd_capture_en | output | 1 | Read data expected on the bus this cycle |
| wr_drive_en | output | 1 | Write drivers on (preamble plus write beats) |
| wr_dm_window | output | 1 | Write data beats occupy the bus this cycle |

## Verification
The bench probes off-by-one placement at both latency extremes. A design that counts one register too many or too few would shift every strobe by a cycle, and the bench sees that in a cycle-exact comparison. Collision runs send a command every cycle into a busy window and look for one refusal per overlapping cycle and an acceptance at the exact abutting cycle. A design that checked only the first data cycle, or left marks behind for refused commands, would show stray read cycles. The read-to-write gap is probed one cycle too early and at the legal cycle, and write followed directly by read is also run. Configuration loads are tried while busy, together with a command, and with illegal values. Each one is then followed by a read whose latency shows whether the settings changed.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

   // Occupancy tag of one future bus cycle.
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_RD   = 2'd1,
      SLOT_WR   = 2'd2
   } slot_e;

endpackage

// File: rtl/dwin_cfg.sv
module dwin_cfg #(
   parameter int CL_W   = 3,
   parameter int AL_W   = 3,
   parameter int CL_MIN = 3,
   parameter int CL_MAX = 6,
   parameter int AL_MAX = 4,
   parameter int RST_CL = 3,
   parameter int RST_AL = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            quiet_i,
   input  logic [CL_W-1:0] cl_i,
   input  logic [AL_W-1:0] al_i,
   input  logic            bl8_i,
   output logic [CL_W-1:0] cl_o,
   output logic [AL_W-1:0] al_o,
   output logic            bl8_o
);

   logic legal_w;
   logic take_w;

   assign legal_w = (cl_i >= CL_W'(CL_MIN)) && (cl_i <= CL_W'(CL_MAX)) &&
                    (al_i <= AL_W'(AL_MAX));
   assign take_w  = load_i && quiet_i && legal_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_o  <= CL_W'(RST_CL);
         al_o  <= AL_W'(RST_AL);
         bl8_o <= 1'b0;
      end else if (take_w) begin
         cl_o  <= cl_i;
         al_o  <= al_i;
         bl8_o <= bl8_i;
      end
   end

endmodule

// File: rtl/dwin_timeline.sv
module dwin_timeline
   import dwin_pkg::*;
#(
   parameter int DEPTH = 14,
   parameter int IW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_i,
   input  slot_e         kind_i,
   input  logic [IW-1:0] lat_i,
   input  logic [IW-1:0] blen_i,
   output slot_e         slot_o [DEPTH],
   output logic          busy_o
);

   // Slot j holds the tag of the bus cycle j cycles from now.
   slot_e slot_q [DEPTH];
   logic [IW:0] end_w;
   logic [DEPTH-1:0] used_w;

   assign end_w = {1'b0, lat_i} + {1'b0, blen_i};

   for (genvar j = 0; j < DEPTH; j++) begin : g_slot
      localparam int NXT = j + 1;
      slot_e src_w;
      logic  hit_w;

      if (j == DEPTH - 1) begin : g_tail
         assign src_w = SLOT_IDLE;
      end else begin : g_body
         assign src_w = slot_q[j+1];
      end

      assign hit_w = ins_i && ((IW+1)'(NXT) >= {1'b0, lat_i}) &&
                     ((IW+1)'(NXT) < end_w);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[j] <= SLOT_IDLE;
         end else begin
            slot_q[j] <= hit_w ? kind_i : src_w;
         end
      end

      assign slot_o[j] = slot_q[j];
      assign used_w[j] = (slot_q[j] != SLOT_IDLE);
   end

   assign busy_o = |used_w;

endmodule

// File: rtl/dwin_conflict.sv
module dwin_conflict
   import dwin_pkg::*;
#(
   parameter int DEPTH = 14,
   parameter int IW    = 4
) (
   input  slot_e         slot_i [DEPTH],
   input  logic          is_wr_i,
   input  logic [IW-1:0] lat_i,
   input  logic [IW-1:0] blen_i,
   output logic          hit_o
);

   logic [IW:0] end_w;
   logic [DEPTH-1:0] clash_w;

   assign end_w = {1'b0, lat_i} + {1'b0, blen_i};

   for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      localparam int NXT = j + 1;
      logic in_win_w;
      logic gap_w;

      assign in_win_w = ((IW+1)'(j) >= {1'b0, lat_i}) && ((IW+1)'(j) < end_w);
      // A write needs the cycle ahead of its data free of read data.
      assign gap_w    = is_wr_i && ((IW+1)'(NXT) == {1'b0, lat_i}) &&
                        (slot_i[j] == SLOT_RD);
      assign clash_w[j] = (in_win_w && (slot_i[j] != SLOT_IDLE)) || gap_w;
   end

   assign hit_o = |clash_w;

endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
   import dwin_pkg::*;
#(
   parameter int CL_W            = 3,
   parameter int AL_W            = 3,
   parameter int CL_MIN          = 3,
   parameter int CL_MAX          = 6,
   parameter int AL_MAX          = 4,
   parameter int BURST_MAX_BEATS = 8,
   parameter int RST_CL          = 3,
   parameter int RST_AL          = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic [CL_W-1:0] cfg_cl,
   input  logic [AL_W-1:0] cfg_al,
   input  logic            cfg_bl8,
   input  logic            cmd_valid,
   input  logic            cmd_write,
   output logic            cmd_accept,
   output logic            cmd_collide,
   output logic            rd_capture_en,
   output logic            wr_drive_en,
   output logic            wr_dm_window
);

   localparam int RL_MAX    = AL_MAX + CL_MAX;
   localparam int CYC_LONG  = BURST_MAX_BEATS / 2;
   localparam int CYC_SHORT = BURST_MAX_BEATS / 4;
   localparam int DEPTH     = RL_MAX + CYC_LONG;
   localparam int IW        = $clog2(DEPTH + 2);

   if (CL_MIN < 3) begin : g_bad_clmin
      $error("CL_MIN must leave room for the write preamble");
   end
   if (CL_MAX >= (1 << CL_W) || CL_MAX < CL_MIN) begin : g_bad_clmax
      $error("CL_MAX out of range for CL_W");
   end
   if (AL_MAX >= (1 << AL_W)) begin : g_bad_almax
      $error("AL_MAX does not fit AL_W");
   end
   if (BURST_MAX_BEATS < 4 || (BURST_MAX_BEATS % 4) != 0) begin : g_bad_burst
      $error("BURST_MAX_BEATS must be a multiple of 4");
   end
   if (RST_CL < CL_MIN || RST_CL > CL_MAX || RST_AL > AL_MAX) begin : g_bad_rst
      $error("reset latency settings are illegal");
   end

   logic [CL_W-1:0] cl_q;
   logic [AL_W-1:0] al_q;
   logic            bl8_q;
   logic            busy_w;
   logic            hit_w;
   logic [IW-1:0]   rl_w;
   logic [IW-1:0]   lat_w;
   logic [IW-1:0]   blen_w;
   slot_e           kind_w;
   slot_e           slot_w [DEPTH];

   dwin_cfg #(
      .CL_W(CL_W), .AL_W(AL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
      .AL_MAX(AL_MAX), .RST_CL(RST_CL), .RST_AL(RST_AL)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .load_i(cfg_load),
      .quiet_i(!busy_w && !cmd_valid),
      .cl_i(cfg_cl), .al_i(cfg_al), .bl8_i(cfg_bl8),
      .cl_o(cl_q), .al_o(al_q), .bl8_o(bl8_q)
   );

   assign rl_w   = IW'(al_q) + IW'(cl_q);
   assign lat_w  = cmd_write ? (rl_w - IW'(1)) : rl_w;
   assign blen_w = bl8_q ? IW'(CYC_LONG) : IW'(CYC_SHORT);
   assign kind_w = cmd_write ? SLOT_WR : SLOT_RD;

   dwin_conflict #(.DEPTH(DEPTH), .IW(IW)) conflict_i (
      .slot_i(slot_w), .is_wr_i(cmd_write), .lat_i(lat_w),
      .blen_i(blen_w), .hit_o(hit_w)
   );

   assign cmd_accept  = cmd_valid && !hit_w;
   assign cmd_collide = cmd_valid && hit_w;

   dwin_timeline #(.DEPTH(DEPTH), .IW(IW)) timeline_i (
      .clk(clk), .rst_n(rst_n), .ins_i(cmd_accept), .kind_i(kind_w),
      .lat_i(lat_w), .blen_i(blen_w), .slot_o(slot_w), .busy_o(busy_w)
   );

   assign rd_capture_en = (slot_w[0] == SLOT_RD);
   assign wr_dm_window  = (slot_w[0] == SLOT_WR);
   assign wr_drive_en   = wr_dm_window || (slot_w[1] == SLOT_WR);

endmodule

// File: rtl/posted_cas_sched_chk.sv
module posted_cas_sched_chk #(
   parameter int CL_W   = 3,
   parameter int AL_W   = 3,
   parameter int CL_MIN = 3,
   parameter int CL_MAX = 6,
   parameter int AL_MAX = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            cmd_accept,
   input logic            cmd_collide,
   input logic            rd_capture_en,
   input logic            wr_drive_en,
   input logic            wr_dm_window,
   input logic            busy,
   input logic [CL_W-1:0] cl_q,
   input logic [AL_W-1:0] al_q,
   input logic            bl8_q
);

   AST_ACC_COL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_accept && cmd_collide)); // R10
   AST_NO_CMD_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (!cmd_accept && !cmd_collide)); // R10
   AST_DM_UNDER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dm_window |-> wr_drive_en); // R4
   AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_drive_en && !wr_dm_window) |=> wr_dm_window); // R4
   AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_capture_en && wr_drive_en)); // R7
   AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_capture_en) |-> !wr_dm_window); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cl_q) && $stable(al_q) && $stable(bl8_q))); // R8
   AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_q >= CL_W'(CL_MIN)) && (cl_q <= CL_W'(CL_MAX)) &&
      (al_q <= AL_W'(AL_MAX))); // R9

endmodule

bind posted_cas_sched posted_cas_sched_chk #(
   .CL_W(CL_W), .AL_W(AL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_accept(cmd_accept),
   .cmd_collide(cmd_collide), .rd_capture_en(rd_capture_en),
   .wr_drive_en(wr_drive_en), .wr_dm_window(wr_dm_window), .busy(busy_w),
   .cl_q(cl_q), .al_q(al_q), .bl8_q(bl8_q)
);

// File: tb/posted_cas_sched_tb_top.sv
module posted_cas_sched_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic [2:0] cfg_cl = 3'd0;
   logic [2:0] cfg_al = 3'd0;
   logic       cfg_bl8 = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_write = 1'b0;
   logic       cmd_accept, cmd_collide, rd_capture_en, wr_drive_en, wr_dm_window;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   bit exp_rd [4096];
   bit exp_dm [4096];
   bit exp_drv [4096];
   bit act_rd [4096];
   bit act_dm [4096];
   bit act_drv [4096];

   int m_cl = 3;
   int m_al = 0;
   bit m_bl8 = 1'b0;

   posted_cas_sched dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cl(cfg_cl),
      .cfg_al(cfg_al), .cfg_bl8(cfg_bl8), .cmd_valid(cmd_valid),
      .cmd_write(cmd_write), .cmd_accept(cmd_accept), .cmd_collide(cmd_collide),
      .rd_capture_en(rd_capture_en), .wr_drive_en(wr_drive_en),
      .wr_dm_window(wr_dm_window)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (cyc < 4096) begin
         act_rd[cyc]  = rd_capture_en;
         act_dm[cyc]  = wr_dm_window;
         act_drv[cyc] = wr_drive_en;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                  req, what, cyc, act, exp);
      end
   endtask

   // Expected strobes of an accepted command, from R2/R3/R4/R5.
   task automatic mark(input int c, input bit w);
      int lat = m_al + m_cl - (w ? 1 : 0);
      int b = m_bl8 ? 4 : 2;
      for (int k = 0; k < b; k++) begin
         if (w) exp_dm[c+lat+k] = 1'b1;
         else   exp_rd[c+lat+k] = 1'b1;
      end
      if (w) begin
         for (int k = -1; k < b; k++) exp_drv[c+lat+k] = 1'b1;
      end
   endtask

   task automatic issue(input bit w, input bit exp_acc, input string req);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_write = w;
      #1;
      chk(cmd_accept === exp_acc, req, "cmd_accept", int'(cmd_accept), int'(exp_acc));
      chk(cmd_collide === !exp_acc, req, "cmd_collide", int'(cmd_collide), int'(!exp_acc));
      if (exp_acc) mark(cyc, w);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic set_cfg(input int cl, input int al, input bit bl8, input bit taken);
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_cl = 3'(cl);
      cfg_al = 3'(al);
      cfg_bl8 = bl8;
      @(posedge clk);
      #1 cfg_load = 1'b0;
      if (taken) begin
         m_cl = cl;
         m_al = al;
         m_bl8 = bl8;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_window(input int from, input int upto, input string req);
      for (int c = from; c <= upto; c++) begin
         chk(act_rd[c] == exp_rd[c], req, "rd_capture_en", int'(act_rd[c]), int'(exp_rd[c]));
         chk(act_dm[c] == exp_dm[c], req, "wr_dm_window", int'(act_dm[c]), int'(exp_dm[c]));
         chk(act_drv[c] == exp_drv[c], req, "wr_drive_en", int'(act_drv[c]), int'(exp_drv[c]));
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(!rd_capture_en && !wr_drive_en && !wr_dm_window, "R1", "strobes in reset",
          int'({rd_capture_en, wr_drive_en, wr_dm_window}), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!cmd_accept && !cmd_collide, "R10", "response with no command",
          int'({cmd_accept, cmd_collide}), 0);
      chk(!rd_capture_en && !wr_drive_en && !wr_dm_window, "R1", "strobes after reset",
          int'({rd_capture_en, wr_drive_en, wr_dm_window}), 0);
   endtask

   // Reset configuration: CL3 AL0 four beats (R1, R2, R3, R4).
   task automatic t_default;
      int s = cyc;
      issue(1'b0, 1'b1, "R2");
      idle(6);
      issue(1'b1, 1'b1, "R3");
      idle(8);
      check_window(s, cyc - 1, "R1/R2/R3/R4");
   endtask

   // Longer latencies and eight beats (R2, R3, R5).
   task automatic t_long;
      int s = cyc;
      set_cfg(5, 2, 1'b1, 1'b1);
      issue(1'b1, 1'b1, "R3");
      idle(14);
      issue(1'b0, 1'b1, "R2");
      idle(14);
      check_window(s, cyc - 1, "R5");
   endtask

   // Loads while busy or alongside a command are ignored (R8).
   task automatic t_cfg_busy;
      int s = cyc;
      issue(1'b0, 1'b1, "R8");
      set_cfg(3, 0, 1'b0, 1'b0);
      idle(14);
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_cl = 3'd4;
      cfg_al = 3'd1;
      cfg_bl8 = 1'b0;
      cmd_valid = 1'b1;
      cmd_write = 1'b0;
      #1;
      chk(cmd_accept === 1'b1, "R8", "accept with load", int'(cmd_accept), 1);
      mark(cyc, 1'b0);
      @(posedge clk);
      #1;
      cfg_load = 1'b0;
      cmd_valid = 1'b0;
      idle(14);
      issue(1'b0, 1'b1, "R8");
      idle(14);
      check_window(s, cyc - 1, "R8");
   endtask

   // Illegal values leave settings as they were (R9).
   task automatic t_cfg_illegal;
      int s = cyc;
      set_cfg(7, 0, 1'b0, 1'b0);
      set_cfg(2, 0, 1'b0, 1'b0);
      set_cfg(3, 5, 1'b0, 1'b0);
      issue(1'b0, 1'b1, "R9");
      idle(14);
      check_window(s, cyc - 1, "R9");
   endtask

   // Overlap refusals and an abutting acceptance (R6).
   task automatic t_collide;
      int s;
      set_cfg(3, 0, 1'b1, 1'b1);
      s = cyc;
      issue(1'b0, 1'b1, "R6");
      issue(1'b0, 1'b0, "R6");
      issue(1'b0, 1'b0, "R6");
      issue(1'b0, 1'b0, "R6");
      issue(1'b0, 1'b1, "R6");
      idle(14);
      check_window(s, cyc - 1, "R6");
   endtask

   // Read-to-write gap and write directly followed by read (R7).
   task automatic t_turn;
      int s;
      set_cfg(4, 0, 1'b0, 1'b1);
      s = cyc;
      issue(1'b0, 1'b1, "R7");
      issue(1'b1, 1'b0, "R7");
      issue(1'b1, 1'b0, "R7");
      issue(1'b1, 1'b0, "R7");
      issue(1'b1, 1'b1, "R7");
      idle(12);
      issue(1'b1, 1'b1, "R7");
      issue(1'b0, 1'b1, "R7");
      idle(12);
      check_window(s, cyc - 1, "R7");
   endtask

   // Largest latency, several bursts in flight (R11).
   task automatic t_deep;
      int s;
      set_cfg(6, 4, 1'b0, 1'b1);
      s = cyc;
      issue(1'b0, 1'b1, "R11");
      issue(1'b0, 1'b0, "R11");
      issue(1'b0, 1'b1, "R11");
      issue(1'b0, 1'b0, "R11");
      issue(1'b0, 1'b1, "R11");
      issue(1'b0, 1'b0, "R11");
      issue(1'b0, 1'b1, "R11");
      idle(20);
      check_window(s, cyc - 1, "R11");
   endtask

   initial begin
      t_reset();
      t_default();
      t_long();
      t_cfg_busy();
      t_cfg_illegal();
      t_collide();
      t_turn();
      t_deep();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule